// File: doc/BRIEF.md
# Peripheral Address Decoder with Relocatable Window

This block sits between a host register bus and a group of byte-wide peripheral targets. It covers a 2 MiB address region that starts at a fixed base address. The region is cut into 256-byte pages. Page 0 selects an external system-control register page. Page 1 holds two configuration registers that live inside the block. The remaining pages can reach a 256-byte data window for a storage controller. Software places that window at run time by writing a base register and setting an enable flag.

The host issues one request at a time: a byte, a 16-bit or a 32-bit access. The block breaks every request into byte accesses, one per clock, with the lowest address first. For each byte it drives one target select strobe and an in-page offset. For reads it picks the byte from that target and packs the bytes into a little-endian response word. While a request is in progress, a busy flag holds off new requests.

Top module: `periph_window_decoder`

## Requirements
- R1: After reset, busy, rsp_valid, sys_sel, win_sel and tgt_write are low, the window is disabled, and the window base reads back as zero.
- R2: A byte whose offset from the region base is in 0x000–0x0FF asserts sys_sel, drives that offset on tgt_offset, and takes its read data from sys_rdata.
- R3: Configuration offset 0x04 (region offset 0x104) is the command register. Bit 1 of a write sets or clears the window enable, the other bits are ignored, and a read returns 0x02 when enabled and 0x00 otherwise.
- R4: Configuration offsets 0x10+k, for k from 0 to 3, hold byte k of the 32-bit window base. A write there replaces only that byte, and a read returns it. Other configuration offsets read as zero.
- R5: A byte outside pages 0 and 1 asserts win_sel, and takes its read data from win_rdata, only when the window is enabled and the region offset with its low 8 bits cleared equals the programmed base. A base with nonzero low bits never matches.
- R6: Pages 0 and 1 win over the window, even when the base is programmed onto one of them.
- R7: A byte below the region base, at or above base+0x200000, or inside the region but matching no target asserts no select strobe and reads as zero. A write there is dropped.
- R8: Size 0 is one byte, size 1 is two bytes, and sizes 2 and 3 are four bytes. Byte k goes to address addr+k and carries write-data bits [8k+7:8k]. Read byte k lands in rsp_rdata bits [8k+7:8k]. A request may cross a page boundary, and each byte is decoded on its own.
- R9: A request is accepted on an edge where req_valid is high and busy is low. Byte k is presented in the (k+1)-th cycle after acceptance, with busy high. rsp_valid pulses for one cycle, with busy low, in the cycle after the last byte. Requests seen while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| req_addr | input | 32 | Byte address of the lowest byte |
| req_wdata | input | 32 | Write data, little-endian |
| busy | output | 1 | Request in progress; new requests are ignored |
| rsp_valid | output | 1 | One-cycle pulse when a request completes |
| rsp_rdata | output | 32 | Assembled read data, valid with rsp_valid |
| sys_sel | output | 1 | Select for the system-control page |
| win_sel | output | 1 | Select for the data window |
| tgt_write | output | 1 | Current byte access is a write |
| tgt_offset | output | 8 | In-page offset of the current byte |
| tgt_wdata | output | 8 | Write byte for the current access |
| sys_rdata | input | 8 | Read byte from the system-control page |
| win_rdata | input | 8 | Read byte from the data window |

## Verification
Every offset of page 0 is swept with byte reads, and every offset of the programmed window page is swept as well. The two targets return different functions of the offset, so a wrong select, a wrong offset or a wrong data mux shows up as a wrong byte. The window is then moved: to an unaligned base, to the last page, and onto pages 0 and 1. The enable is also toggled. These cases separate a correct base compare from an enable that is ignored and from a priority that is inverted. Half-word and word accesses that cross page boundaries, and addresses just outside the region, check the byte order, the per-byte decoding and the zero data returned on a miss. A conflicting request is held on the bus during most accesses, which shows that nothing is accepted while busy.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  // Access size encoding on req_size
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD3 = 2'd3
  } acc_size_e;

  // Configuration page register offsets
  localparam int unsigned CFG_CMD_OFF  = 'h04;
  localparam int unsigned CFG_BASE_OFF = 'h10;
  localparam int unsigned CMD_EN_BIT   = 1;
endpackage

// File: rtl/pwd_byte_seq.sv
module pwd_byte_seq #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned ACC_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [1:0]               req_size,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [ACC_BYTES*8-1:0]   req_wdata,
  input  logic [7:0]               rd_byte,
  output logic                     busy,
  output logic                     rsp_valid,
  output logic [ACC_BYTES*8-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]        byte_addr,
  output logic                     byte_write,
  output logic [7:0]               byte_wdata
);
  import pwd_pkg::*;

  localparam int unsigned IDX_W  = (ACC_BYTES > 1) ? $clog2(ACC_BYTES) : 1;
  localparam int unsigned DATA_W = ACC_BYTES * 8;

  logic              active_q, active_d;
  logic              rsp_q, rsp_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [IDX_W-1:0]  last_q, last_d;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              accept, acc_en;

  assign accept = req_valid & ~active_q;
  assign acc_en = accept | (active_q & ~wr_q);

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    rsp_d    = 1'b0;
    acc_d    = acc_q;
    last_d   = last_q;
    if (accept) begin
      active_d = 1'b1;
      idx_d    = '0;
      acc_d    = '0;
      unique case (acc_size_e'(req_size))
        SZ_BYTE: last_d = '0;
        SZ_HALF: last_d = IDX_W'(1);
        default: last_d = IDX_W'(ACC_BYTES - 1);
      endcase
    end else if (active_q) begin
      if (!wr_q) acc_d[idx_q*8 +: 8] = rd_byte;
      if (idx_q == last_q) begin
        active_d = 1'b0;
        rsp_d    = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rsp_q    <= 1'b0;
      idx_q    <= '0;
      last_q   <= '0;
      addr_q   <= '0;
      wr_q     <= 1'b0;
      wdata_q  <= '0;
      acc_q    <= '0;
    end else begin
      active_q <= active_d;
      rsp_q    <= rsp_d;
      idx_q    <= idx_d;
      if (accept) begin
        last_q  <= last_d;
        addr_q  <= req_addr;
        wr_q    <= req_write;
        wdata_q <= req_wdata;
      end
      if (acc_en) acc_q <= acc_d;
    end
  end

  assign busy       = active_q;
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = acc_q;
  assign byte_addr  = addr_q + ADDR_W'(idx_q);
  assign byte_write = active_q & wr_q;
  assign byte_wdata = wdata_q[idx_q*8 +: 8];
endmodule

// File: rtl/pwd_page_route.sv
module pwd_page_route #(
  parameter int unsigned       ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] REGION_BASE = '0,
  parameter int unsigned       REGION_LOG2 = 21,
  parameter int unsigned       PAGE_LOG2   = 8
) (
  input  logic                 byte_valid,
  input  logic [ADDR_W-1:0]    byte_addr,
  input  logic                 win_en,
  input  logic [ADDR_W-1:0]    win_base,
  input  logic [7:0]           sys_rdata,
  input  logic [7:0]           cfg_rdata,
  input  logic [7:0]           win_rdata,
  output logic                 sys_hit,
  output logic                 cfg_hit,
  output logic                 win_hit,
  output logic [PAGE_LOG2-1:0] offset,
  output logic [7:0]           rd_byte
);
  localparam int unsigned PIDX_W = REGION_LOG2 - PAGE_LOG2;

  logic [ADDR_W-1:0] diff;
  logic [ADDR_W-1:0] page_base;
  logic [PIDX_W-1:0] page_idx;
  logic              in_region;

  assign diff      = byte_addr - REGION_BASE;
  assign in_region = (diff >> REGION_LOG2) == '0;
  assign page_idx  = diff[REGION_LOG2-1:PAGE_LOG2];
  assign page_base = {diff[ADDR_W-1:PAGE_LOG2], {PAGE_LOG2{1'b0}}};
  assign offset    = diff[PAGE_LOG2-1:0];

  // Fixed pages first; window only above them
  assign sys_hit = byte_valid & in_region & (page_idx == '0);
  assign cfg_hit = byte_valid & in_region & (page_idx == PIDX_W'(1));
  assign win_hit = byte_valid & in_region & (page_idx > PIDX_W'(1)) &
                   win_en & (page_base == win_base);

  always_comb begin
    rd_byte = 8'h00;
    if (sys_hit)      rd_byte = sys_rdata;
    else if (cfg_hit) rd_byte = cfg_rdata;
    else if (win_hit) rd_byte = win_rdata;
  end
endmodule

// File: rtl/pwd_cfg_regs.sv
module pwd_cfg_regs #(
  parameter int unsigned PAGE_LOG2 = 8,
  parameter int unsigned BASE_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 write,
  input  logic [PAGE_LOG2-1:0] offset,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic                 win_en,
  output logic [BASE_W-1:0]    win_base
);
  import pwd_pkg::*;

  localparam int unsigned BASE_BYTES = BASE_W / 8;

  logic en_q, en_d, en_we;

  assign en_we = sel & write & (offset == PAGE_LOG2'(CFG_CMD_OFF));
  assign en_d  = wdata[CMD_EN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_we) en_q <= en_d;
  end

  for (genvar k = 0; k < BASE_BYTES; k++) begin : g_base
    logic [7:0] byte_q;
    logic       byte_we;
    assign byte_we = sel & write & (offset == PAGE_LOG2'(CFG_BASE_OFF + k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= 8'h00;
      else if (byte_we) byte_q <= wdata;
    end
    assign win_base[k*8 +: 8] = byte_q;
  end

  always_comb begin
    rdata = 8'h00;
    if (offset == PAGE_LOG2'(CFG_CMD_OFF)) rdata[CMD_EN_BIT] = en_q;
    for (int k = 0; k < BASE_BYTES; k++) begin
      if (offset == PAGE_LOG2'(CFG_BASE_OFF + k)) rdata = win_base[k*8 +: 8];
    end
  end

  assign win_en = en_q;
endmodule

// File: rtl/periph_window_decoder.sv
module periph_window_decoder #(
  parameter int unsigned       ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h4000_0000,
  parameter int unsigned       REGION_LOG2 = 21,
  parameter int unsigned       PAGE_LOG2   = 8,
  parameter int unsigned       ACC_BYTES   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [1:0]             req_size,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [ACC_BYTES*8-1:0] req_wdata,
  output logic                   busy,
  output logic                   rsp_valid,
  output logic [ACC_BYTES*8-1:0] rsp_rdata,
  output logic                   sys_sel,
  output logic                   win_sel,
  output logic                   tgt_write,
  output logic [PAGE_LOG2-1:0]   tgt_offset,
  output logic [7:0]             tgt_wdata,
  input  logic [7:0]             sys_rdata,
  input  logic [7:0]             win_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [ADDR_W-1:0] byte_addr;
  logic              byte_write;
  logic [7:0]        byte_wdata;
  logic [7:0]        rd_byte;
  logic [7:0]        cfg_rdata;
  logic              sys_hit, cfg_hit, win_hit;
  logic              win_en;
  logic [ADDR_W-1:0] win_base;

  pwd_byte_seq #(.ADDR_W(ADDR_W), .ACC_BYTES(ACC_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_byte(rd_byte),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .byte_addr(byte_addr), .byte_write(byte_write), .byte_wdata(byte_wdata)
  );

  pwd_page_route #(
    .ADDR_W(ADDR_W), .REGION_BASE(REGION_BASE),
    .REGION_LOG2(REGION_LOG2), .PAGE_LOG2(PAGE_LOG2)
  ) u_route (
    .byte_valid(busy), .byte_addr(byte_addr),
    .win_en(win_en), .win_base(win_base),
    .sys_rdata(sys_rdata), .cfg_rdata(cfg_rdata), .win_rdata(win_rdata),
    .sys_hit(sys_hit), .cfg_hit(cfg_hit), .win_hit(win_hit),
    .offset(tgt_offset), .rd_byte(rd_byte)
  );

  pwd_cfg_regs #(.PAGE_LOG2(PAGE_LOG2), .BASE_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n),
    .sel(cfg_hit), .write(byte_write), .offset(tgt_offset),
    .wdata(byte_wdata), .rdata(cfg_rdata),
    .win_en(win_en), .win_base(win_base)
  );

  assign sys_sel   = sys_hit;
  assign win_sel   = win_hit;
  assign tgt_write = byte_write;
  assign tgt_wdata = byte_wdata;
endmodule

// File: rtl/pwd_checker.sv
module pwd_checker #(
  parameter int unsigned MAX_RUN = 4
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic rsp_valid,
  input logic sys_sel,
  input logic cfg_hit,
  input logic win_sel,
  input logic win_en,
  input logic tgt_write
);
  localparam int unsigned RUN_W = $clog2(MAX_RUN + 1) + 1;

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  // R9
  rsp_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(busy) && !busy));

  // R5
  win_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_sel |-> win_en);

  // R6
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sys_sel, cfg_hit, win_sel}));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(sys_sel || win_sel || cfg_hit || tgt_write));

  // R8
  byte_run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < RUN_W'(MAX_RUN)));
endmodule

bind periph_window_decoder pwd_checker #(.MAX_RUN(ACC_BYTES)) u_pwd_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .busy(busy),
  .rsp_valid(rsp_valid), .sys_sel(sys_sel), .cfg_hit(cfg_hit),
  .win_sel(win_sel), .win_en(win_en), .tgt_write(tgt_write)
);

// File: tb/tb_periph_window_decoder.sv
`timescale 1ns/1ps
module tb_periph_window_decoder;
  localparam logic [31:0] RB = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        busy, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        sys_sel, win_sel, tgt_write;
  logic [7:0]  tgt_offset, tgt_wdata, sys_rdata, win_rdata;

  int n_chk = 0;
  int n_bad = 0;

  logic        m_en;
  logic [31:0] m_base;

  always #2 clk = ~clk;

  // Targets return distinct functions of the offset
  assign sys_rdata = tgt_offset ^ 8'h5A;
  assign win_rdata = tgt_offset + 8'h33;

  periph_window_decoder #(.REGION_BASE(RB)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sys_sel(sys_sel), .win_sel(win_sel), .tgt_write(tgt_write),
    .tgt_offset(tgt_offset), .tgt_wdata(tgt_wdata),
    .sys_rdata(sys_rdata), .win_rdata(win_rdata)
  );

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // 0 none, 1 system page, 2 config page, 3 window
  function automatic int kind_of(input logic [31:0] a);
    logic [31:0] d;
    d = a - RB;
    if (d >= 32'h20_0000) return 0;
    if ((d >> 8) == 0) return 1;
    if ((d >> 8) == 1) return 2;
    if (m_en && ((d & 32'hFFFF_FF00) == m_base)) return 3;
    return 0;
  endfunction

  function automatic logic [7:0] cfg_read(input logic [7:0] o);
    if (o == 8'h04) return m_en ? 8'h02 : 8'h00;
    if (o >= 8'h10 && o <= 8'h13) return m_base[(o - 8'h10) * 8 +: 8];
    return 8'h00;
  endfunction

  task automatic access(input logic wr, input logic [1:0] sz,
                        input logic [31:0] a, input logic [31:0] wd,
                        input logic noisy, input string tag);
    int          n;
    logic [31:0] exp_rd;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    exp_rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    if (noisy) begin
      req_addr = a ^ 32'h0000_0A00; req_write = ~wr; req_wdata = ~wd;
    end else begin
      req_valid = 1'b0;
    end
    for (int k = 0; k < n; k++) begin
      logic [31:0] ba;
      logic [7:0]  off, rb;
      int          kd;
      ba  = a + 32'(k);
      off = 8'(ba - RB);
      kd  = kind_of(ba);
      chk(busy === 1'b1 && rsp_valid === 1'b0, "R9", "busy/rsp in byte", {busy, rsp_valid}, 2'b10);
      chk(sys_sel === (kd == 1), tag, "sys_sel", sys_sel, kd == 1);
      chk(win_sel === (kd == 3), tag, "win_sel", win_sel, kd == 3);
      if (kd == 1 || kd == 3) begin
        chk(tgt_offset === off, "R8", "offset", tgt_offset, off);
        chk(tgt_write === wr, "R8", "write", tgt_write, wr);
        if (wr) chk(tgt_wdata === wd[k*8 +: 8], "R8", "wdata", tgt_wdata, wd[k*8 +: 8]);
      end
      rb = (kd == 1) ? (off ^ 8'h5A) : (kd == 3) ? (off + 8'h33) :
           (kd == 2) ? cfg_read(off) : 8'h00;
      if (!wr) exp_rd[k*8 +: 8] = rb;
      if (wr && kd == 2) begin
        if (off == 8'h04) m_en = wd[k*8 + 1];
        if (off >= 8'h10 && off <= 8'h13) m_base[(off - 8'h10) * 8 +: 8] = wd[k*8 +: 8];
      end
      @(posedge clk);
      @(negedge clk);
    end
    chk(rsp_valid === 1'b1 && busy === 1'b0, "R9", "rsp end", {busy, rsp_valid}, 2'b01);
    if (!wr) chk(rsp_rdata === exp_rd, tag, "rdata", rsp_rdata, exp_rd);
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0 && rsp_valid === 1'b0, "R9", "idle after", {busy, rsp_valid}, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_en = 1'b0; m_base = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(busy === 1'b0 && rsp_valid === 1'b0, "R1", "busy/rsp", {busy, rsp_valid}, 0);
    chk(sys_sel === 1'b0 && win_sel === 1'b0 && tgt_write === 1'b0, "R1", "selects",
        {sys_sel, win_sel, tgt_write}, 0);
    access(1'b0, 2'd0, RB + 32'h104, 0, 1'b0, "R1");
    access(1'b0, 2'd2, RB + 32'h110, 0, 1'b0, "R1");

    // R2: full sweep of the system page
    for (int o = 0; o < 256; o++) access(1'b0, 2'd0, RB + 32'(o), 0, o[0], "R2");
    for (int o = 0; o < 256; o += 17) access(1'b1, 2'd0, RB + 32'(o), 32'(o * 3), 1'b1, "R2");

    // R3: command register, only bit 1 matters
    access(1'b1, 2'd0, RB + 32'h104, 32'h02, 1'b1, "R3");
    access(1'b0, 2'd0, RB + 32'h104, 0, 1'b0, "R3");
    access(1'b1, 2'd0, RB + 32'h104, 32'hFD, 1'b1, "R3");
    access(1'b0, 2'd0, RB + 32'h104, 0, 1'b1, "R3");
    access(1'b1, 2'd0, RB + 32'h104, 32'h02, 1'b0, "R3");

    // R4: base bytes written one at a time, read back in several sizes
    for (int k = 0; k < 4; k++) access(1'b1, 2'd0, RB + 32'h110 + 32'(k), 32'hA0 + 32'(k), 1'b1, "R4");
    access(1'b0, 2'd2, RB + 32'h110, 0, 1'b0, "R4");
    access(1'b0, 2'd1, RB + 32'h112, 0, 1'b1, "R4");
    access(1'b0, 2'd2, RB + 32'h100, 0, 1'b0, "R4");
    access(1'b0, 2'd2, RB + 32'h114, 0, 1'b1, "R4");

    // R5: window at region offset 0x12300, swept fully
    access(1'b1, 2'd2, RB + 32'h110, 32'h0001_2300, 1'b1, "R5");
    for (int o = 0; o < 256; o++) access(1'b0, 2'd0, RB + 32'h12300 + 32'(o), 0, o[1], "R5");
    for (int o = 0; o < 256; o += 23) access(1'b1, 2'd0, RB + 32'h12300 + 32'(o), 32'(o + 9), 1'b1, "R5");
    access(1'b1, 2'd0, RB + 32'h104, 32'h00, 1'b0, "R5");
    access(1'b0, 2'd0, RB + 32'h12340, 0, 1'b1, "R5");
    access(1'b1, 2'd0, RB + 32'h12341, 32'h77, 1'b1, "R5");
    access(1'b1, 2'd0, RB + 32'h104, 32'h02, 1'b0, "R5");
    access(1'b1, 2'd2, RB + 32'h110, 32'h001F_FF00, 1'b1, "R5");
    access(1'b0, 2'd0, RB + 32'h1FFF80, 0, 1'b0, "R5");
    access(1'b0, 2'd2, RB + 32'h1FFFFE, 0, 1'b1, "R5");
    access(1'b1, 2'd2, RB + 32'h110, 32'h0001_2345, 1'b1, "R5");
    access(1'b0, 2'd0, RB + 32'h12300, 0, 1'b0, "R5");
    access(1'b0, 2'd0, RB + 32'h12345, 0, 1'b1, "R5");

    // R6: base placed on the fixed pages
    access(1'b1, 2'd2, RB + 32'h110, 32'h0000_0000, 1'b1, "R6");
    access(1'b0, 2'd0, RB + 32'h10, 0, 1'b0, "R6");
    access(1'b1, 2'd0, RB + 32'hC0, 32'h3C, 1'b1, "R6");
    access(1'b1, 2'd2, RB + 32'h110, 32'h0000_0100, 1'b1, "R6");
    access(1'b0, 2'd0, RB + 32'h104, 0, 1'b0, "R6");
    access(1'b0, 2'd2, RB + 32'h110, 0, 1'b1, "R6");

    // R7: misses inside and outside the region
    access(1'b1, 2'd2, RB + 32'h110, 32'h0000_4400, 1'b0, "R7");
    access(1'b0, 2'd0, RB - 32'h1, 0, 1'b1, "R7");
    access(1'b0, 2'd2, RB - 32'h100, 0, 1'b0, "R7");
    access(1'b0, 2'd0, RB + 32'h20_0000, 0, 1'b1, "R7");
    access(1'b0, 2'd1, RB + 32'h3F_FF00, 0, 1'b0, "R7");
    access(1'b0, 2'd0, RB + 32'h5500, 0, 1'b1, "R7");
    access(1'b1, 2'd2, RB + 32'h200, 32'hDEAD_BEEF, 1'b1, "R7");
    access(1'b1, 2'd0, RB + 32'h20_0010, 32'h11, 1'b0, "R7");
    access(1'b0, 2'd2, RB + 32'h110, 0, 1'b0, "R7");

    // R8: wide accesses, byte order and page crossings
    access(1'b0, 2'd1, RB + 32'hFF, 0, 1'b1, "R8");
    access(1'b0, 2'd2, RB + 32'hFE, 0, 1'b0, "R8");
    access(1'b0, 2'd3, RB + 32'h1FE, 0, 1'b1, "R8");
    access(1'b1, 2'd2, RB + 32'h44F0, 32'h8765_4321, 1'b1, "R8");
    access(1'b0, 2'd2, RB + 32'h44FE, 0, 1'b0, "R8");
    access(1'b0, 2'd3, RB + 32'h43FE, 0, 1'b1, "R8");
    access(1'b1, 2'd3, RB + 32'h10, 32'hCAFE_F00D, 1'b0, "R8");
    access(1'b1, 2'd1, RB + 32'h44FF, 32'h0000_9A5B, 1'b1, "R8");
    access(1'b0, 2'd1, RB + 32'h1FFFFF, 0, 1'b0, "R8");

    // R9: back-to-back requests with a conflicting request held while busy
    for (int i = 0; i < 8; i++) access(1'b0, 2'(i % 4), RB + 32'h4480 + 32'(i * 5), 0, 1'b1, "R9");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule